// File: doc/BRIEF.md
# Keyed and Sticky Configuration Write Guard

This block sits between a register bus and a bank of configuration registers and decides, cycle by cycle, whether a write may land. It classifies each write by address into one of four groups: the key register, a sticky-guarded group (which contains the global control register), a key-guarded group, and a free group. It then raises exactly one of three write-enable qualifiers, or none. The protected registers themselves are outside this block. Each register in a group uses the matching qualifier as its write enable.

The key-guarded group opens only after two specific bytes are written to the key register in order. It stays open for one write only: the first later write to a guarded register, or to the key register, closes it again. The sticky-guarded group is closed by writing a one to bit 31 of the global control register. That lock can only be cleared by reset. The current key state is reported on a two-bit output so that software can read it.

Write strobe, address and data are plain control inputs with no back-pressure. Every strobed cycle is one complete write, and the qualifiers are combinational for that same cycle.

Top module: `cfg_wr_guard`

## Requirements
- R1: After reset, key_state reads 0 (closed) and the sticky lock is clear, so writes to the sticky-guarded group are enabled.
- R2: key_state encodes the key state as 0 = closed, 1 = armed, 2 = open. It never shows 3.
- R3: In the closed state, a key-register write whose data bits 7:0 equal 0xA5 moves the state to armed. Any other value leaves it closed.
- R4: In the armed state, a key-register write whose data bits 7:0 equal 0xF1 moves the state to open. Any other value returns it to closed.
- R5: In the open state, any key-register write returns the state to closed.
- R6: A key-guarded write (address 0x20 to 0x3F) raises keyed_we only in the open state. That write completes and returns the state to closed.
- R7: A key-guarded write in the closed or armed state is discarded (keyed_we low) and leaves the key state unchanged.
- R8: A write to the global control register (address 0x01) with bit 31 set, made while the lock is clear, completes (sticky_we high) and sets the sticky lock from the next cycle on.
- R9: While the sticky lock is set, every sticky-guarded write (address 0x01 to 0x0F) is discarded (sticky_we low), including writes to the control register that try to clear bit 31. Only reset clears the lock.
- R10: Writes to the free group (any other address except the key register at 0x10) always raise free_we.
- R11: At most one qualifier is high in any cycle. None is high without wr_en or for a key-register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| wr_addr | input | 8 | Register word address |
| wr_data | input | 32 | Write data |
| keyed_we | output | 1 | Write enable for the key-guarded group |
| sticky_we | output | 1 | Write enable for the sticky-guarded group |
| free_we | output | 1 | Write enable for unguarded registers |
| key_state | output | 2 | Key state: 0 closed, 1 armed, 2 open |

## Verification
The hardest situation to reach is a guarded write arriving in the open state: it needs two exact key bytes in order, with nothing in between that closes the key. Pure random data would almost never produce this. The stimulus therefore draws key data mostly from the two magic bytes, and a bench model tracks the state so the open-state write is both reached and checked. A second hard case is a sticky lock combined with a later key unlock. Directed sequences set the lock and then prove that control writes stay blocked while key-guarded writes still work, until reset clears the lock.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;
  typedef enum logic [1:0] {
    KS_CLOSED = 2'd0,
    KS_ARMED  = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_e;

  typedef enum logic [2:0] {
    GRP_IDLE   = 3'd0,
    GRP_KEY    = 3'd1,
    GRP_STICKY = 3'd2,
    GRP_KEYED  = 3'd3,
    GRP_FREE   = 3'd4
  } wr_group_e;
endpackage

// File: rtl/cfg_wr_decode.sv
module cfg_wr_decode
  import cfg_guard_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int KEY_ADDR  = 'h10,
  parameter int STICKY_LO = 'h01,
  parameter int STICKY_HI = 'h0F,
  parameter int KEYED_LO  = 'h20,
  parameter int KEYED_HI  = 'h3F
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output wr_group_e         grp
);
  localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(KEY_ADDR);
  localparam logic [ADDR_W-1:0] S_LO  = ADDR_W'(STICKY_LO);
  localparam logic [ADDR_W-1:0] S_HI  = ADDR_W'(STICKY_HI);
  localparam logic [ADDR_W-1:0] K_LO  = ADDR_W'(KEYED_LO);
  localparam logic [ADDR_W-1:0] K_HI  = ADDR_W'(KEYED_HI);

  logic hit_key, hit_sticky, hit_keyed;

  assign hit_key    = (wr_addr == KEY_A);
  assign hit_sticky = (wr_addr >= S_LO) && (wr_addr <= S_HI);
  assign hit_keyed  = (wr_addr >= K_LO) && (wr_addr <= K_HI);

  always_comb begin
    if (!wr_en)          grp = GRP_IDLE;
    else if (hit_key)    grp = GRP_KEY;
    else if (hit_sticky) grp = GRP_STICKY;
    else if (hit_keyed)  grp = GRP_KEYED;
    else                 grp = GRP_FREE;
  end
endmodule

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
  import cfg_guard_pkg::*;
#(
  parameter int KEY_W      = 8,
  parameter int KEY_FIRST  = 'hA5,
  parameter int KEY_SECOND = 'hF1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_byte,
  input  logic             keyed_req,
  output key_state_e       state,
  output logic             is_open
);
  localparam logic [KEY_W-1:0] K1 = KEY_W'(KEY_FIRST);
  localparam logic [KEY_W-1:0] K2 = KEY_W'(KEY_SECOND);

  key_state_e nxt;

  always_comb begin
    nxt = state;
    if (key_wr) begin
      unique case (state)
        KS_CLOSED: nxt = (key_byte == K1) ? KS_ARMED : KS_CLOSED;
        KS_ARMED:  nxt = (key_byte == K2) ? KS_OPEN  : KS_CLOSED;
        default:   nxt = KS_CLOSED;
      endcase
    end else if (keyed_req && state == KS_OPEN) begin
      nxt = KS_CLOSED;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= KS_CLOSED;
    else        state <= nxt;
  end

  assign is_open = (state == KS_OPEN);

  // R4
  arm_to_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr && state == KS_ARMED && key_byte == K2 |=> state == KS_OPEN);

  // R5
  open_key_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr && state == KS_OPEN |=> state == KS_CLOSED);

  // R7
  blocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    keyed_req && !key_wr && state != KS_OPEN |=> $stable(state));
endmodule

// File: rtl/cfg_sticky_lock.sv
module cfg_sticky_lock #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int CTRL_ADDR = 'h01,
  parameter int LOCK_BIT  = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sticky_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              locked
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  logic set_req;
  assign set_req = sticky_req && !locked && (wr_addr == CTRL_A) && wr_data[LOCK_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n)       locked <= 1'b0;
    else if (set_req) locked <= 1'b1;
  end

  // R8
  lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_req && (wr_addr == CTRL_A) && wr_data[LOCK_BIT] |=> locked);
endmodule

// File: rtl/cfg_wr_guard.sv
module cfg_wr_guard
  import cfg_guard_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int KEY_W      = 8,
  parameter int KEY_ADDR   = 'h10,
  parameter int CTRL_ADDR  = 'h01,
  parameter int LOCK_BIT   = 31,
  parameter int STICKY_LO  = 'h01,
  parameter int STICKY_HI  = 'h0F,
  parameter int KEYED_LO   = 'h20,
  parameter int KEYED_HI   = 'h3F,
  parameter int KEY_FIRST  = 'hA5,
  parameter int KEY_SECOND = 'hF1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              keyed_we,
  output logic              sticky_we,
  output logic              free_we,
  output logic [1:0]        key_state
);
  wr_group_e  grp;
  key_state_e ks;
  logic       ks_open, locked;
  logic       key_wr, sticky_req, keyed_req;

  cfg_wr_decode #(
    .ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR),
    .STICKY_LO(STICKY_LO), .STICKY_HI(STICKY_HI),
    .KEYED_LO(KEYED_LO), .KEYED_HI(KEYED_HI)
  ) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .grp(grp)
  );

  assign key_wr     = (grp == GRP_KEY);
  assign sticky_req = (grp == GRP_STICKY);
  assign keyed_req  = (grp == GRP_KEYED);

  cfg_key_fsm #(
    .KEY_W(KEY_W), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
  ) u_key (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr),
    .key_byte(wr_data[KEY_W-1:0]), .keyed_req(keyed_req),
    .state(ks), .is_open(ks_open)
  );

  cfg_sticky_lock #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .LOCK_BIT(LOCK_BIT)
  ) u_lock (
    .clk(clk), .rst_n(rst_n), .sticky_req(sticky_req),
    .wr_addr(wr_addr), .wr_data(wr_data), .locked(locked)
  );

  assign keyed_we  = keyed_req && ks_open;
  assign sticky_we = sticky_req && !locked;
  assign free_we   = (grp == GRP_FREE);
  assign key_state = ks;

  // R6
  keyed_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    keyed_we |=> key_state == 2'd0);

  // R9
  lock_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !sticky_we);

  // R11
  one_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({keyed_we, sticky_we, free_we}));

  // R2
  state_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_state != 2'd3);
endmodule

// File: tb/cfg_wr_guard_tb_top.sv
module cfg_wr_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        keyed_we, sticky_we, free_we;
  logic [1:0]  key_state;

  int total = 0;
  int bad = 0;
  int m_state = 0;
  bit m_lock = 1'b0;

  always #4 clk = ~clk;

  cfg_wr_guard dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .keyed_we(keyed_we), .sticky_we(sticky_we), .free_we(free_we), .key_state(key_state)
  );

  // 0 idle, 1 key, 2 sticky, 3 keyed, 4 free
  function automatic int grp_of(bit en, logic [7:0] a);
    if (!en) return 0;
    if (a == 8'h10) return 1;
    if (a >= 8'h01 && a <= 8'h0F) return 2;
    if (a >= 8'h20 && a <= 8'h3F) return 3;
    return 4;
  endfunction

  function automatic int next_state(int s, int g, logic [7:0] d);
    if (g == 1) begin
      if (s == 0) return (d == 8'hA5) ? 1 : 0;
      if (s == 1) return (d == 8'hF1) ? 2 : 0;
      return 0;
    end
    if (g == 3 && s == 2) return 0;
    return s;
  endfunction

  task automatic check(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_state = 0;
    m_lock = 1'b0;
    #1;
    check("R1 key_state after reset", key_state, 0);
  endtask

  task automatic do_op(bit en, logic [7:0] a, logic [31:0] d);
    int g;
    @(negedge clk);
    check("R2 key_state", key_state, m_state);
    wr_en = en;
    wr_addr = a;
    wr_data = d;
    g = grp_of(en, a);
    #1;
    check(g == 3 ? "R6/R7 keyed_we" : "R11 keyed_we", keyed_we, (g == 3 && m_state == 2) ? 1 : 0);
    check(g == 2 ? "R8/R9 sticky_we" : "R11 sticky_we", sticky_we, (g == 2 && !m_lock) ? 1 : 0);
    check("R10 free_we", free_we, (g == 4) ? 1 : 0);
    @(posedge clk);
    if (g == 2 && !m_lock && a == 8'h01 && d[31]) m_lock = 1'b1;
    m_state = next_state(m_state, g, d[7:0]);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic expect_state(string req, int exp);
    @(negedge clk);
    check(req, key_state, exp);
  endtask

  initial begin
    #1500000;
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED1);
    do_reset();
    // R1 sticky write passes after reset
    do_op(1, 8'h05, 32'h0);
    // R3 wrong first byte stays closed
    do_op(1, 8'h10, 32'h0000_00F1);
    expect_state("R3 wrong first byte", 0);
    // R3 upper bits ignored, only bits 7:0 compared
    do_op(1, 8'h10, 32'hFFFF_FFA5);
    expect_state("R3 armed", 1);
    // R7 keyed write while armed blocked, state unchanged
    do_op(1, 8'h20, 32'h1);
    expect_state("R7 armed hold", 1);
    // R4 wrong second byte closes
    do_op(1, 8'h10, 32'hA5);
    expect_state("R4 wrong second", 0);
    // R4 / R6 full unlock then one write
    do_op(1, 8'h10, 32'hA5);
    do_op(1, 8'h10, 32'hF1);
    expect_state("R4 open", 2);
    do_op(1, 8'h00, 32'h0);
    expect_state("R10 free write keeps open", 2);
    do_op(1, 8'h3F, 32'h1234);
    expect_state("R6 relock", 0);
    do_op(1, 8'h3F, 32'h1234);
    // R5 key write while open closes
    do_op(1, 8'h10, 32'hA5);
    do_op(1, 8'h10, 32'hF1);
    do_op(1, 8'h10, 32'hA5);
    expect_state("R5 key write closes", 0);
    // R8 / R9 sticky lock
    do_op(1, 8'h01, 32'h8000_0000);
    do_op(1, 8'h01, 32'h0);
    do_op(1, 8'h0F, 32'h55);
    do_op(1, 8'h10, 32'hA5);
    do_op(1, 8'h10, 32'hF1);
    do_op(1, 8'h25, 32'h7);
    do_op(0, 8'h20, 32'h0);
    do_reset();
    do_op(1, 8'h01, 32'h0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int pick;
      logic [7:0] a;
      logic [31:0] d;
      pick = $urandom_range(0, 99);
      d = $urandom();
      if (pick < 40) begin
        a = 8'h10;
        case ($urandom_range(0, 2))
          0: d[7:0] = 8'hA5;
          1: d[7:0] = 8'hF1;
          default: ;
        endcase
      end else if (pick < 55) begin
        a = 8'($urandom_range(8'h01, 8'h0F));
        if (!(a == 8'h01 && $urandom_range(0, 30) == 0)) d[31] = 1'b0;
      end else if (pick < 80) begin
        a = 8'($urandom_range(8'h20, 8'h3F));
      end else if (pick < 92) begin
        a = 8'($urandom_range(8'h40, 8'hFF));
      end else begin
        a = 8'($urandom());
      end
      do_op(pick % 13 != 0, a, d);
      if (i % 500 == 499) do_reset();
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule